// File: doc/BRIEF.md
# Event-Driven Interrupt Timer with Prescaler

This block is a programmable interrupt timer for a cartridge-style memory mapper. An 8-bit prescaler feeds an 8-bit main counter. Both count in the same direction, up or down, and the main counter raises a level interrupt request when it wraps. The counting events come from one of four strobes, chosen by software: a CPU cycle strobe, a scanline strobe, a PPU read with its address, and a CPU write strobe. Logic outside the block produces these strobes.

Software reaches the block through a byte-wide write port with eight offsets. These offsets set the mode, the enable and the key, and they load the two counters. A loaded value is stored XORed with the key. An event that stands for several ticks is spread over consecutive clocks. Each tick therefore sees the prescaler value left by the tick before it, and ticks from events that overlap add up.

Top module: `evt_irq_timer`

## Requirements
- R1: After reset, irq_o is 0 and every register is 0. With the mode at 0 the counters are stopped, so CPU cycle strobes never raise irq_o.
- R2: Mode bits 1:0 select the only event source that counts: 0 is cpu_cycle_i (1 tick), 1 is line_evt_i, 2 is a PPU read, 3 is cpu_wr_i (1 tick). Strobes from the other sources have no effect.
- R3: In source 1, each line_evt_i pulse gives 8 ticks. The first tick is in the cycle of the pulse and the other 7 follow on the next 7 clocks.
- R4: In source 2, a ppu_rd_i whose ppu_addr_i differs from the last address read in this source gives 2 ticks. A read of the same address gives none. The stored address is 0 after reset.
- R5: Mode bits 7:6 set the direction: 01 counts up and 10 counts down. The values 00 and 11 freeze both counters.
- R6: When mode bit 2 is 1, the prescaler mask is 0x07. When it is 0, the mask is 0xFF.
- R7: On each tick the prescaler steps by one. Counting up, it clocks the main counter when its masked bits become 0. Counting down, it clocks the main counter when its masked bits become equal to the mask.
- R8: When the main counter wraps to 0x00 counting up, or to 0xFF counting down, while the enable is 1, irq_o goes to 1 at that same clock edge. It then stays 1 until it is cleared.
- R9: A write to offset 4 loads the prescaler and a write to offset 5 loads the main counter. Each load stores the data XORed with the key written at offset 6. A load takes priority over a tick in the same cycle.
- R10: A write to offset 0 sets the enable from data bit 0, and a 0 in that bit also clears irq_o. A write to offset 2 disables and clears. A write to offset 3 enables and leaves irq_o as it is.
- R11: A write to offset 1 stores the mode. A write to offset 7 has no effect on counting or on irq_o.
- R12: Ticks from events that overlap are queued and add up, up to a pending total of 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| cpu_cycle_i | input | 1 | CPU cycle strobe |
| line_evt_i | input | 1 | Scanline event strobe |
| ppu_rd_i | input | 1 | PPU read strobe |
| ppu_addr_i | input | 14 | PPU read address |
| cpu_wr_i | input | 1 | CPU write strobe |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is ticks from several events overlapping in the pending queue, together with a carry that lands exactly on a wrap. Only irq_o can be observed. To reach this case, the bench loads the counters one step or a few steps short of a wrap and then sends back-to-back scanline pulses, or a mix of new and repeated PPU addresses. It checks irq_o on the cycle before the predicted wrap and on the cycle of the wrap. A behavioural model, stepped on every clock, also checks the loads scrambled by a non-zero key and the rules for which write clears or enables the request.

// File: rtl/evt_irq_pkg.sv
`timescale 1ns/1ps
package evt_irq_pkg;
  localparam int DATA_W = 8;
  localparam int REG_AW = 3;

  typedef enum logic [1:0] {
    SRC_CPU  = 2'd0,
    SRC_LINE = 2'd1,
    SRC_PPU  = 2'd2,
    SRC_WR   = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2,
    DIR_FRZ  = 2'd3
  } dir_e;

  localparam logic [REG_AW-1:0] OFF_EN   = 3'd0;
  localparam logic [REG_AW-1:0] OFF_MODE = 3'd1;
  localparam logic [REG_AW-1:0] OFF_OFF  = 3'd2;
  localparam logic [REG_AW-1:0] OFF_ON   = 3'd3;
  localparam logic [REG_AW-1:0] OFF_PRE  = 3'd4;
  localparam logic [REG_AW-1:0] OFF_CNT  = 3'd5;
  localparam logic [REG_AW-1:0] OFF_KEY  = 3'd6;
endpackage

// File: rtl/evt_irq_regs.sv
`timescale 1ns/1ps
module evt_irq_regs
  import evt_irq_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = REG_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output src_e          src_o,
  output logic          short_o,
  output dir_e          dir_o,
  output logic          en_o,
  output logic          clr_o,
  output logic          pre_ld_o,
  output logic          cnt_ld_o,
  output logic [DW-1:0] ld_val_o
);
  src_e          src_q;
  dir_e          dir_q;
  logic          short_q;
  logic          en_q;
  logic [DW-1:0] key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= SRC_CPU;
      dir_q   <= DIR_HOLD;
      short_q <= 1'b0;
      en_q    <= 1'b0;
      key_q   <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        OFF_MODE: begin
          src_q   <= src_e'(wdata_i[1:0]);
          short_q <= wdata_i[2];
          dir_q   <= dir_e'(wdata_i[7:6]);
        end
        OFF_EN:  en_q  <= wdata_i[0];
        OFF_OFF: en_q  <= 1'b0;
        OFF_ON:  en_q  <= 1'b1;
        OFF_KEY: key_q <= wdata_i;
        default: ; // offset 7 and counter loads: no register here
      endcase
    end
  end

  assign src_o    = src_q;
  assign short_o  = short_q;
  assign dir_o    = dir_q;
  assign en_o     = en_q;
  assign clr_o    = we_i && ((addr_i == OFF_OFF) || (addr_i == OFF_EN && !wdata_i[0]));
  assign pre_ld_o = we_i && (addr_i == OFF_PRE);
  assign cnt_ld_o = we_i && (addr_i == OFF_CNT);
  assign ld_val_o = wdata_i ^ key_q;
endmodule

// File: rtl/evt_irq_tick.sv
`timescale 1ns/1ps
module evt_irq_tick
  import evt_irq_pkg::*;
#(
  parameter int PAW        = 14,
  parameter int PEND_W     = 6,
  parameter int LINE_TICKS = 8,
  parameter int PPU_TICKS  = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  src_e           src_i,
  input  logic           cpu_cycle_i,
  input  logic           line_i,
  input  logic           ppu_rd_i,
  input  logic [PAW-1:0] ppu_addr_i,
  input  logic           cpu_wr_i,
  output logic           tick_o
);
  localparam int SW = PEND_W + 1;
  localparam logic [SW-1:0] PEND_MAX = SW'((1 << PEND_W) - 1);

  logic [PEND_W-1:0] pend_q, pend_d;
  logic [PAW-1:0]    last_q;
  logic [SW-1:0]     n_ev, sum_w;

  always_comb begin
    n_ev = '0;
    unique case (src_i)
      SRC_CPU:  if (cpu_cycle_i) n_ev = SW'(1);
      SRC_LINE: if (line_i) n_ev = SW'(LINE_TICKS);
      SRC_PPU:  if (ppu_rd_i && ppu_addr_i != last_q) n_ev = SW'(PPU_TICKS);
      default:  if (cpu_wr_i) n_ev = SW'(1);
    endcase
  end

  assign tick_o = (pend_q != '0) || (n_ev != '0);
  assign sum_w  = {1'b0, pend_q} + n_ev - {{(SW-1){1'b0}}, tick_o};
  assign pend_d = (sum_w > PEND_MAX) ? PEND_MAX[PEND_W-1:0] : sum_w[PEND_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      last_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (src_i == SRC_PPU && ppu_rd_i) last_q <= ppu_addr_i;
    end
  end

  // R3: a scanline into an empty queue leaves the remaining ticks pending
  a_r3_line_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_LINE && line_i && pend_q == '0) |=> pend_q == PEND_W'(LINE_TICKS - 1));

  // R4: a repeated PPU address adds nothing to an empty queue
  a_r4_ppu_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_PPU && ppu_rd_i && ppu_addr_i == last_q && pend_q == '0) |-> !tick_o);
endmodule

// File: rtl/evt_irq_pre.sv
`timescale 1ns/1ps
module evt_irq_pre
  import evt_irq_pkg::*;
#(
  parameter int W       = DATA_W,
  parameter int SHORT_W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  dir_e         dir_i,
  input  logic         short_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic         carry_o
);
  localparam logic [W-1:0] MASK_S = W'((1 << SHORT_W) - 1);
  localparam logic [W-1:0] MASK_L = '1;

  logic [W-1:0] pre_q, pre_nxt, mask;
  logic         up, run;

  assign up      = (dir_i == DIR_UP);
  assign run     = up || (dir_i == DIR_DOWN);
  assign mask    = short_i ? MASK_S : MASK_L;
  assign pre_nxt = up ? pre_q + 1'b1 : pre_q - 1'b1;
  assign carry_o = tick_i && run && !ld_i &&
                   ((pre_nxt & mask) == (up ? '0 : mask));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pre_q <= '0;
    else if (ld_i)            pre_q <= ld_val_i;
    else if (tick_i && run)   pre_q <= pre_nxt;
  end

  // R5: a frozen direction leaves the prescaler untouched
  a_r5_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !ld_i) |=> $stable(pre_q));

  // R9: a load stores the scrambled value from the register stage
  a_r9_pre_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> pre_q == $past(ld_val_i));
endmodule

// File: rtl/evt_irq_main.sv
`timescale 1ns/1ps
module evt_irq_main
  import evt_irq_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         carry_i,
  input  dir_e         dir_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         en_i,
  input  logic         clr_i,
  output logic         irq_o
);
  logic [W-1:0] cnt_q, cnt_nxt;
  logic         up, wrap, irq_q;

  assign up      = (dir_i == DIR_UP);
  assign cnt_nxt = up ? cnt_q + 1'b1 : cnt_q - 1'b1;
  assign wrap    = carry_i && !ld_i && (up ? (cnt_nxt == '0) : (cnt_nxt == '1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (ld_i)         cnt_q <= ld_val_i;
      else if (carry_i) cnt_q <= cnt_nxt;
      if (clr_i)             irq_q <= 1'b0;
      else if (wrap && en_i) irq_q <= 1'b1;
    end
  end

  assign irq_o = irq_q;

  // R8: request is a held level
  a_r8_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !clr_i) |=> irq_q);

  // R10: a clearing write drops the request
  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !irq_q);

  // R8: no request rises without the enable
  a_r8_need_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_q && !en_i) |=> !irq_q);
endmodule

// File: rtl/evt_irq_timer.sv
`timescale 1ns/1ps
module evt_irq_timer
  import evt_irq_pkg::*;
#(
  parameter int DW     = DATA_W,
  parameter int AW     = REG_AW,
  parameter int PAW    = 14,
  parameter int PEND_W = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [AW-1:0]  reg_addr_i,
  input  logic [DW-1:0]  reg_wdata_i,
  input  logic           cpu_cycle_i,
  input  logic           line_evt_i,
  input  logic           ppu_rd_i,
  input  logic [PAW-1:0] ppu_addr_i,
  input  logic           cpu_wr_i,
  output logic           irq_o
);
  src_e          src;
  dir_e          dir;
  logic          short_pre, en, clr, pre_ld, cnt_ld, tick, carry;
  logic [DW-1:0] ld_val;

  evt_irq_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .src_o(src), .short_o(short_pre), .dir_o(dir), .en_o(en),
    .clr_o(clr), .pre_ld_o(pre_ld), .cnt_ld_o(cnt_ld), .ld_val_o(ld_val)
  );

  evt_irq_tick #(.PAW(PAW), .PEND_W(PEND_W)) u_tick (
    .clk_i, .rst_ni, .src_i(src),
    .cpu_cycle_i, .line_i(line_evt_i), .ppu_rd_i, .ppu_addr_i, .cpu_wr_i,
    .tick_o(tick)
  );

  evt_irq_pre #(.W(DW)) u_pre (
    .clk_i, .rst_ni, .tick_i(tick), .dir_i(dir), .short_i(short_pre),
    .ld_i(pre_ld), .ld_val_i(ld_val), .carry_o(carry)
  );

  evt_irq_main #(.W(DW)) u_main (
    .clk_i, .rst_ni, .carry_i(carry), .dir_i(dir),
    .ld_i(cnt_ld), .ld_val_i(ld_val), .en_i(en), .clr_i(clr), .irq_o
  );
endmodule

// File: tb/evt_irq_timer_test.sv
`timescale 1ns/1ps
module evt_irq_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        cpu_cycle = 1'b0, line_evt = 1'b0, ppu_rd = 1'b0, cpu_wr = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  evt_irq_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .cpu_cycle_i(cpu_cycle), .line_evt_i(line_evt), .ppu_rd_i(ppu_rd),
    .ppu_addr_i(ppu_addr), .cpu_wr_i(cpu_wr), .irq_o(irq)
  );

  // behavioural reference
  int m_mode, m_key, m_pre, m_cnt, m_pend, m_last;
  bit m_en, m_irq;

  task automatic model_step();
    int nev, dir, mask, tk;
    bit car, wrp;
    nev = 0; car = 0; wrp = 0;
    dir  = (m_mode >> 6) & 3;
    mask = ((m_mode >> 2) & 1) ? 7 : 255;
    case (m_mode & 3)
      0: if (cpu_cycle) nev = 1;
      1: if (line_evt) nev = 8;
      2: if (ppu_rd) begin
           if (int'(ppu_addr) != m_last) nev = 2;
           m_last = int'(ppu_addr);
         end
      default: if (cpu_wr) nev = 1;
    endcase
    tk = (m_pend > 0 || nev > 0) ? 1 : 0;
    m_pend = m_pend + nev - tk;
    if (m_pend > 63) m_pend = 63;
    if (we && addr == 4) m_pre = int'(wdata) ^ m_key;
    else if (tk == 1 && (dir == 1 || dir == 2)) begin
      m_pre = (dir == 1) ? (m_pre + 1) & 255 : (m_pre + 255) & 255;
      car = (dir == 1) ? ((m_pre & mask) == 0) : ((m_pre & mask) == mask);
    end
    if (we && addr == 5) m_cnt = int'(wdata) ^ m_key;
    else if (car) begin
      m_cnt = (dir == 1) ? (m_cnt + 1) & 255 : (m_cnt + 255) & 255;
      wrp = (dir == 1) ? (m_cnt == 0) : (m_cnt == 255);
    end
    if (we && (addr == 2 || (addr == 0 && !wdata[0]))) m_irq = 0;
    else if (wrp && m_en) m_irq = 1;
    if (we) case (addr)
      0: m_en = wdata[0];
      1: m_mode = int'(wdata);
      2: m_en = 0;
      3: m_en = 1;
      6: m_key = int'(wdata);
      default: ;
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_key = 0; m_pre = 0; m_cnt = 0; m_pend = 0; m_last = 0;
      m_en = 0; m_irq = 0;
    end else model_step();
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq !== m_irq) begin
        errors++;
        $display("FAIL R8 model: irq_o=%0b expected %0b at %0t", irq, m_irq, $time);
      end
    end
  end

  task automatic chk(input bit exp, input string tag);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s: irq_o=%0b expected %0b", tag, irq, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // kind: 0 cpu cycle, 1 scanline, 3 cpu write
  task automatic pulse(input int kind, input int n);
    for (int i = 0; i < n; i++) begin
      cpu_cycle = (kind == 0); line_evt = (kind == 1); cpu_wr = (kind == 3);
      @(negedge clk);
    end
    cpu_cycle = 0; line_evt = 0; cpu_wr = 0;
  endtask

  task automatic ppu(input logic [13:0] a);
    ppu_rd = 1'b1; ppu_addr = a;
    @(negedge clk);
    ppu_rd = 1'b0;
  endtask

  task automatic setup(input logic [7:0] mode, input logic [7:0] key,
                       input logic [7:0] pre, input logic [7:0] cnt);
    wr(3'd1, 8'h00);
    idle(20);
    wr(3'd6, key);
    wr(3'd4, pre);
    wr(3'd5, cnt);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h00);
    wr(3'd1, mode);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(1'b0, "R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    wr(3'd3, 8'h00);
    pulse(0, 300);
    chk(1'b0, "R1 stopped after reset");

    // up, short prescaler, cpu cycles
    setup(8'h44, 8'h00, 8'h00, 8'hFF);
    pulse(0, 7);
    chk(1'b0, "R7 before carry");
    pulse(0, 1);
    chk(1'b1, "R7 R8 wrap up");
    idle(5);
    chk(1'b1, "R8 level held");
    wr(3'd3, 8'h00);
    chk(1'b1, "R10 enable keeps request");
    wr(3'd7, 8'hFF);
    chk(1'b1, "R11 offset 7 no effect");
    wr(3'd0, 8'h01);
    chk(1'b1, "R10 offset 0 set keeps request");
    wr(3'd0, 8'h00);
    chk(1'b0, "R10 offset 0 clear");

    // down, full prescaler, scrambled loads
    setup(8'h80, 8'h5A, 8'h5A, 8'h5A);
    pulse(0, 1);
    chk(1'b1, "R9 key scrambled loads, R6 down");
    wr(3'd2, 8'h00);
    chk(1'b0, "R10 offset 2 clear");

    // frozen directions
    setup(8'hC4, 8'h00, 8'h00, 8'hFF);
    pulse(0, 40);
    chk(1'b0, "R5 dir 11 frozen");
    setup(8'h04, 8'h00, 8'h00, 8'hFF);
    pulse(0, 40);
    chk(1'b0, "R5 dir 00 frozen");

    // scanline burst
    setup(8'h45, 8'h00, 8'h00, 8'hFF);
    pulse(1, 1);
    idle(6);
    chk(1'b0, "R3 seven ticks");
    idle(1);
    chk(1'b1, "R3 eighth tick");

    // ppu address changes
    setup(8'h46, 8'h00, 8'h00, 8'hFF);
    ppu(14'h100); ppu(14'h100); ppu(14'h200); ppu(14'h200); ppu(14'h300);
    idle(3);
    chk(1'b0, "R4 six ticks");
    ppu(14'h300);
    idle(3);
    chk(1'b0, "R4 repeat address ignored");
    ppu(14'h100);
    idle(3);
    chk(1'b1, "R4 eighth tick");

    // source selection: cpu write
    setup(8'h47, 8'h00, 8'h00, 8'hFF);
    pulse(0, 20);
    pulse(1, 3);
    ppu(14'h055);
    idle(30);
    chk(1'b0, "R2 other sources ignored");
    pulse(3, 7);
    chk(1'b0, "R2 seven writes");
    pulse(3, 1);
    chk(1'b1, "R2 cpu write source");

    // overlapping bursts
    setup(8'h45, 8'h00, 8'h00, 8'hFE);
    pulse(1, 2);
    idle(13);
    chk(1'b0, "R12 fifteen ticks");
    idle(1);
    chk(1'b1, "R12 sixteenth tick");

    // full prescaler up
    setup(8'h40, 8'h00, 8'h00, 8'hFF);
    pulse(0, 255);
    chk(1'b0, "R6 255 ticks");
    pulse(0, 1);
    chk(1'b1, "R6 256 ticks");

    // wrap while disabled
    setup(8'h44, 8'h00, 8'h00, 8'hFF);
    wr(3'd2, 8'h00);
    pulse(0, 8);
    chk(1'b0, "R8 disabled wrap");
    wr(3'd3, 8'h00);
    chk(1'b0, "R10 enable later no request");

    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule